// File: doc/BRIEF.md
# Signed Array Multiplier with Polarity-Tracked Cells

This block multiplies two signed operands of WIDTH bits each and returns their full 2·WIDTH-bit two's complement product. The partial-product bits are summed in a regular grid of three-input adder cells. Any partial-product bit formed from exactly one operand sign bit has negative weight, and the grid subtracts it inside the array. No sign extension of the operands and no correction word are added afterwards.

Each cell is told, at elaboration time, which of its three inputs carry negative weight. From that it selects one of four flavours: all positive, one negative, two negative or all negative. Its sum and carry outputs carry weights whose signs follow from that choice. The polarity of every intermediate bit is computed while the grid is generated. A final two-operand resolve stage turns the last row of sum and carry bits into a binary product. An optional output register gives one cycle of latency and is cleared by a synchronous active-high reset.

Top module: `signed_array_mult`

## Requirements
- R1: For every pair of operands, `prod_o` equals the product of `mcand_i` and `mplier_i`, both read as signed two's complement, as a 2·WIDTH-bit two's complement value.
- R2: With REG_OUT=1, `prod_o` shows the product of the operands present at the previous rising clock edge and holds it until the next edge. With REG_OUT=0, `prod_o` follows the operands within the same cycle.
- R3: With REG_OUT=1, a high `rst` sampled at a rising edge sets `prod_o` to zero at that edge, and `prod_o` stays zero while `rst` remains high, whatever the operands.
- R4: The most negative operand times itself gives the positive value 2^(2·WIDTH−2). Only bit 2·WIDTH−2 of `prod_o` is set, and the top bit is zero.
- R5: When either operand is zero, `prod_o` is zero.
- R6: When both operands are nonzero, the top bit of `prod_o` is 1 exactly when the operands' sign bits differ.
- R7: Swapping the two operands does not change `prod_o`.
- R8: An operand of −1 (all ones) gives the two's complement negation of the other operand, extended to 2·WIDTH bits. For the most negative operand this is +2^(WIDTH−1).
- R9: An operand of +1 gives the other operand sign-extended to 2·WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| prod_o | output | 2*WIDTH | Signed product |

## Verification
A registered product is due at the first rising edge after the operands are applied. The bench therefore drives the operands on a falling edge and reads `prod_o` on the following falling edge. Once, it also reads `prod_o` one nanosecond after new operands appear, to confirm the old value is still held. The combinational instance has no register, so its product is read one nanosecond after each drive, with no clock edge in between. Reset is checked one edge after it is raised and again while it stays high.

// File: rtl/amul_pkg.sv
package amul_pkg;

    // Cell flavour, named by the sign of its three inputs (P = positive, N = negative).
    typedef enum logic [1:0] {
        CELL_PPP,
        CELL_PPN,
        CELL_PNN,
        CELL_NNN
    } cell_kind_e;

    typedef struct packed {
        logic s;
        logic c;
    } cell_out_t;

    function automatic int neg_count(input logic [2:0] mask);
        return int'(mask[0]) + int'(mask[1]) + int'(mask[2]);
    endfunction

    function automatic cell_kind_e kind_of(input logic [2:0] mask);
        case (neg_count(mask))
            0:       return CELL_PPP;
            1:       return CELL_PPN;
            2:       return CELL_PNN;
            default: return CELL_NNN;
        endcase
    endfunction

    // A partial-product bit is negative when exactly one factor is a sign bit.
    function automatic logic pp_neg(input int col_i, input int row_j, input int width);
        return (col_i == width - 1) != (row_j == width - 1);
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/amul_cell.sv
module amul_cell
    import amul_pkg::*;
#(
    parameter logic [2:0] NEG = 3'b000
) (
    input  logic [2:0] bits_i,
    output cell_out_t  out_o
);
    localparam cell_kind_e KIND = kind_of(NEG);
    // Mixed cells invert the input whose sign is in the minority before the majority gate.
    localparam logic [2:0] FLIP = (KIND == CELL_PPN) ? NEG :
                                  (KIND == CELL_PNN) ? ~NEG : 3'b000;

    logic carry;

    if (KIND == CELL_PPP || KIND == CELL_NNN) begin : g_plain
        assign carry = maj3(bits_i[0], bits_i[1], bits_i[2]);
    end else begin : g_mixed
        logic [2:0] adj;
        assign adj   = bits_i ^ FLIP;
        assign carry = maj3(adj[0], adj[1], adj[2]);
    end

    assign out_o = '{s: ^bits_i, c: carry};

endmodule

// File: rtl/amul_array.sv
module amul_array
    import amul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]          mcand_i,
    input  logic [W-1:0]          mplier_i,
    output logic [1:0][2*W-1:0]   pos_o,
    output logic [1:0][2*W-1:0]   neg_o
);
    localparam int COLS = 2 * W;
    typedef logic [W-1:0][COLS-1:0] plane_t;

    // Elaboration-time walk of the grid: polarity of every sum and carry bit.
    function automatic plane_t pol_plane(input logic want_carry);
        plane_t sp;
        plane_t cp;
        int     negs;
        sp = '0;
        cp = '0;
        sp[0][W-1] = pp_neg(W - 1, 0, W);
        for (int j = 1; j < W; j++) begin
            for (int k = j; k < j + W; k++) begin
                negs = int'(pp_neg(k - j, j, W)) + int'(sp[j-1][k]) + int'(cp[j-1][k]);
                sp[j][k]   = negs[0];
                cp[j][k+1] = (negs >= 2);
            end
        end
        return want_carry ? cp : sp;
    endfunction

    localparam plane_t S_POL = pol_plane(1'b0);
    localparam plane_t C_POL = pol_plane(1'b1);

    logic pp  [W][W];
    logic s_w [W][COLS];
    logic c_w [W][COLS];

    for (genvar j = 0; j < W; j++) begin : g_pp_row
        for (genvar i = 0; i < W; i++) begin : g_pp_bit
            assign pp[j][i] = mcand_i[i] & mplier_i[j];
        end
    end

    for (genvar j = 0; j < W; j++) begin : g_lvl
        for (genvar k = 0; k < COLS; k++) begin : g_col
            if (j == 0) begin : g_seed
                if (k < W) begin : g_in
                    assign s_w[0][k] = pp[0][k];
                end else begin : g_out
                    assign s_w[0][k] = 1'b0;
                end
                assign c_w[0][k] = 1'b0;
            end else begin : g_add
                if (k >= j && k < j + W) begin : g_cell
                    localparam logic [2:0] NEG =
                        {C_POL[j-1][k], S_POL[j-1][k], pp_neg(k - j, j, W)};
                    cell_out_t co;
                    amul_cell #(.NEG(NEG)) u_cell (
                        .bits_i ({c_w[j-1][k], s_w[j-1][k], pp[j][k-j]}),
                        .out_o  (co)
                    );
                    assign s_w[j][k]   = co.s;
                    assign c_w[j][k+1] = co.c;
                end else begin : g_idle
                    assign s_w[j][k] = 1'b0;
                end
                if (k <= j || k > j + W) begin : g_nocarry
                    assign c_w[j][k] = 1'b0;
                end
            end
        end
    end

    // Settled bits: low columns leave the grid early, the rest come from the last row.
    always_comb begin
        for (int k = 0; k < COLS; k++) begin
            pos_o[0][k] = s_w[(k < W - 1) ? k : W - 1][k] & ~S_POL[(k < W - 1) ? k : W - 1][k];
            neg_o[0][k] = s_w[(k < W - 1) ? k : W - 1][k] &  S_POL[(k < W - 1) ? k : W - 1][k];
            pos_o[1][k] = c_w[W-1][k] & ~C_POL[W-1][k];
            neg_o[1][k] = c_w[W-1][k] &  C_POL[W-1][k];
        end
    end

endmodule

// File: rtl/amul_resolve.sv
module amul_resolve #(
    parameter int W = 8
) (
    input  logic [1:0][2*W-1:0] pos_i,
    input  logic [1:0][2*W-1:0] neg_i,
    output logic [2*W-1:0]      prod_o
);
    logic [2*W-1:0] pos_sum;
    logic [2*W-1:0] neg_sum;

    assign pos_sum = pos_i[0] + pos_i[1];
    assign neg_sum = neg_i[0] + neg_i[1];
    assign prod_o  = pos_sum - neg_sum;

endmodule

// File: rtl/signed_array_mult.sv
module signed_array_mult #(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] prod_o
);
    localparam int PW = 2 * WIDTH;

    logic [1:0][PW-1:0] pos_w;
    logic [1:0][PW-1:0] neg_w;
    logic [PW-1:0]      prod_c;

    amul_array #(.W(WIDTH)) u_array (
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .pos_o    (pos_w),
        .neg_o    (neg_w)
    );

    amul_resolve #(.W(WIDTH)) u_resolve (
        .pos_i  (pos_w),
        .neg_i  (neg_w),
        .prod_o (prod_c)
    );

    if (REG_OUT) begin : g_reg
        logic [PW-1:0] prod_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q <= '0;
            end else begin
                prod_q <= prod_c;
            end
        end
        assign prod_o = prod_q;
    end else begin : g_comb
        assign prod_o = prod_c;
    end

endmodule

// File: rtl/amul_chk.sv
module amul_chk #(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [WIDTH-1:0]   mcand_i,
    input logic [WIDTH-1:0]   mplier_i,
    input logic [2*WIDTH-1:0] prod_o
);
    localparam int PW = 2 * WIDTH;
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH - 1){1'b0}}};
    localparam logic [PW-1:0]    MIN_SQ   = {2'b01, {(PW - 2){1'b0}}};

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] model;
    logic          any_zero;
    logic          both_set;
    logic          sign_diff;
    logic          min_pair;

    assign a_ext     = {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
    assign b_ext     = {{WIDTH{mplier_i[WIDTH-1]}}, mplier_i};
    assign model     = a_ext * b_ext;
    assign any_zero  = (mcand_i == '0) || (mplier_i == '0);
    assign both_set  = !any_zero;
    assign sign_diff = mcand_i[WIDTH-1] ^ mplier_i[WIDTH-1];
    assign min_pair  = (mcand_i == MOST_NEG) && (mplier_i == MOST_NEG);

    if (REG_OUT) begin : g_seq
        // R1
        prod_match_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> prod_o == $past(model));
        // R3
        rst_clear_chk: assert property (@(posedge clk)
            rst |=> prod_o == '0);
        // R5
        zero_prod_chk: assert property (@(posedge clk) disable iff (rst)
            any_zero |=> prod_o == '0);
        // R4
        min_square_chk: assert property (@(posedge clk) disable iff (rst)
            min_pair |=> prod_o == MIN_SQ);
        // R6
        sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
            both_set |=> prod_o[PW-1] == $past(sign_diff));
    end else begin : g_flow
        // R1
        prod_match_chk: assert property (@(posedge clk) disable iff (rst)
            prod_o == model);
        // R5
        zero_prod_chk: assert property (@(posedge clk) disable iff (rst)
            any_zero |-> prod_o == '0);
        // R4
        min_square_chk: assert property (@(posedge clk) disable iff (rst)
            min_pair |-> prod_o == MIN_SQ);
        // R6
        sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
            both_set |-> prod_o[PW-1] == sign_diff);
    end

endmodule

bind signed_array_mult amul_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/signed_array_mult_tb_top.sv
module signed_array_mult_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  a4  = '0;
    logic [3:0]  b4  = '0;
    logic [7:0]  p4;
    logic [7:0]  a8  = '0;
    logic [7:0]  b8  = '0;
    logic [15:0] p8;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    signed_array_mult #(.WIDTH(4), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .mcand_i(a4), .mplier_i(b4), .prod_o(p4)
    );

    signed_array_mult #(.WIDTH(8), .REG_OUT(1'b0)) dut_w8 (
        .clk(clk), .rst(rst), .mcand_i(a8), .mplier_i(b8), .prod_o(p8)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Registered 4-bit instance: drive on a falling edge, read at the next one.
    task automatic run4(input string req, input int x, input int y, input logic [7:0] exp);
        @(negedge clk);
        a4 = 4'(x);
        b4 = 4'(y);
        @(negedge clk);
        chk(req, {8'h00, p4}, {8'h00, exp});
    endtask

    // Combinational 8-bit instance: read 1 ns after driving.
    task automatic run8(input string req, input int x, input int y, input logic [15:0] exp);
        a8 = 8'(x);
        b8 = 8'(y);
        #1;
        chk(req, p8, exp);
    endtask

    task automatic t_reset_start();
        a4 = 4'd5;
        b4 = 4'd3;
        @(negedge clk);
        chk("R3 start", {8'h00, p4}, 16'h0000);
        @(negedge clk);
        chk("R3 held", {8'h00, p4}, 16'h0000);
        rst = 1'b0;
    endtask

    task automatic t_exhaustive();
        for (int x = -8; x < 8; x++) begin
            for (int y = -8; y < 8; y++) begin
                run4("R1 sweep", x, y, 8'(x * y));
            end
        end
    endtask

    task automatic t_latency();
        run4("R2 first", 2, 3, 8'd6);
        a4 = 4'd3;
        b4 = 4'd5;
        #1;
        chk("R2 hold", {8'h00, p4}, 16'h0006);
        @(negedge clk);
        chk("R2 update", {8'h00, p4}, 16'h000f);
        run8("R2 comb", 7, -9, 16'(7 * -9));
    endtask

    task automatic t_min_square();
        run4("R4 w4", -8, -8, 8'h40);
        run8("R4 w8", -128, -128, 16'h4000);
    endtask

    task automatic t_zero();
        run4("R5 a zero", 0, -8, 8'h00);
        run4("R5 b zero", 7, 0, 8'h00);
        run8("R5 w8 a zero", 0, -128, 16'h0000);
        run8("R5 w8 b zero", -1, 0, 16'h0000);
    endtask

    task automatic t_sign();
        run8("R6 pos neg", 100, -3, 16'(100 * -3));
        chk("R6 msb set", {15'h0, p8[15]}, 16'h0001);
        run8("R6 neg neg", -100, -3, 16'(300));
        chk("R6 msb clear", {15'h0, p8[15]}, 16'h0000);
        run4("R6 w4 neg pos", -1, 1, 8'hff);
    endtask

    task automatic t_commute();
        logic [15:0] first;
        run8("R7 fwd", 113, -57, 16'(113 * -57));
        first = p8;
        run8("R7 rev", -57, 113, first);
        run8("R7 fwd b", -128, 127, 16'(-128 * 127));
        first = p8;
        run8("R7 rev b", 127, -128, first);
    endtask

    task automatic t_neg_one();
        run8("R8 neg min", -128, -1, 16'h0080);
        run8("R8 neg pos", 77, -1, 16'(-77));
        run8("R8 neg neg", -1, -45, 16'(45));
        run4("R8 w4 min", -8, -1, 8'h08);
    endtask

    task automatic t_unit();
        run8("R9 ext neg", -100, 1, 16'(-100));
        run8("R9 ext pos", 1, 127, 16'(127));
        run4("R9 w4", 1, -5, 8'(-5));
    endtask

    task automatic t_reset_mid();
        run4("R3 before", 7, 7, 8'd49);
        @(negedge clk);
        rst = 1'b1;
        a4  = 4'd6;
        b4  = 4'd5;
        @(negedge clk);
        chk("R3 clear", {8'h00, p4}, 16'h0000);
        @(negedge clk);
        chk("R3 stays", {8'h00, p4}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 resume", {8'h00, p4}, 16'd30);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_start();
        t_exhaustive();
        t_latency();
        t_min_square();
        t_zero();
        t_sign();
        t_commute();
        t_neg_one();
        t_unit();
        t_reset_mid();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule